// File: doc/BRIEF.md
# Interrupt Pending and Entry Sequencer

This block decides when a small 8-bit processor core stops its program to serve an interrupt. It also times the entry into the handler and the later return. There are two kinds of source. Event sources store a pending flag that lasts until it is served or cleared. Level sources request service only while their input is high. The core supplies instruction-completion strobes, a sleep indicator and three commands: global enable, global disable and return. The block replies with a vector pulse carrying the winning source index, stack push and pop strobes with the resulting stack pointer, and a stall signal that holds the core while a sequence runs.

Entry and return are fixed-length sequences of `PHASE_CYC` clock cycles, four by default. A source accepted while the core sleeps first pays a wake penalty of the same length. The vector output is a single-cycle pulse with no ready. The core is stalled while the pulse is out and cannot refuse it, so there is no back-pressure anywhere on the block. All other pins are plain control and status levels.

Top module: `irq_entry_seq`

## Requirements
- R1: An event source's pending flag (bit i of `evt_pend`) sets on the clock after `evt_trig[i]`, whatever `evt_en` or the global enable hold. It stays set until served or until `evt_clr[i]` is high. When trigger and clear arrive in the same cycle, the trigger wins.
- R2: When an event source is accepted, its pending flag clears on the same clock edge. Other pending flags are untouched.
- R3: A level source requests only while both `lvl_req` and `lvl_en` are high. A level pulse that ends before its enable rises leaves nothing behind.
- R4: Sources are numbered with the event sources first (0 to NUM_EVT-1) and the level sources after them. Of the eligible sources, the lowest number wins and is reported on `vec_idx`.
- R5: A request is accepted only at a completion point, meaning `insn_done` high with `multi_busy` low, or while `sleeping` is high. Acceptance also needs the global enable set, and it clears the global enable.
- R6: `cmd_gie_clr` blocks acceptance in the very cycle it is asserted, and it clears the global enable.
- R7: The completion point in the cycle of `cmd_gie_set` cannot accept. The next completion point can.
- R8: After a return, or after `cmd_gie_set`, nothing is accepted during sleep until one `insn_done` completion has occurred.
- R9: Entry stalls for 4 cycles after the accepting edge. `sp_push` is high in the first two, and each push lowers `sp` by one. `vec_valid` is high in the fourth cycle.
- R10: Acceptance during sleep adds 4 stall cycles without pushes before the 4 entry cycles.
- R11: `cmd_reti` in idle stalls for 4 cycles with `sp_pop` high in the first two. `sp` rises by two in total, and the global enable is set when the sequence ends.
- R12: After reset the global enable is 0, all pending flags are 0, `stall` is low and `sp` equals `SP_TOP`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_trig | input | NUM_EVT | Event occurrence per event source |
| evt_clr | input | NUM_EVT | Write-one-to-clear of pending flags |
| evt_en | input | NUM_EVT | Per-source enable, event sources |
| lvl_req | input | NUM_LVL | Condition inputs of level sources |
| lvl_en | input | NUM_LVL | Per-source enable, level sources |
| insn_done | input | 1 | An instruction cycle completes |
| multi_busy | input | 1 | Current instruction has cycles left |
| sleeping | input | 1 | Core is in sleep |
| cmd_gie_set | input | 1 | Global enable command |
| cmd_gie_clr | input | 1 | Global disable command |
| cmd_reti | input | 1 | Return-from-interrupt command |
| gie | output | 1 | Global enable state |
| evt_pend | output | NUM_EVT | Pending flags of event sources |
| vec_valid | output | 1 | Vector fetch pulse |
| vec_idx | output | IDX_W | Winning source index |
| sp_push | output | 1 | One byte pushed this cycle |
| sp_pop | output | 1 | One byte popped this cycle |
| sp | output | SP_W | Stack pointer |
| stall | output | 1 | Core held by an entry or return sequence |

## Verification
A wrong sequencer state shows up as `stall` or a push or pop strobe in the wrong cycle. The bench counts these cycle by cycle from the accepting edge, so a miscount becomes visible within the eight-cycle window. A stuck gap or global-enable flag either admits an entry at a blocked completion point or blocks a legal one, and either shows on `stall` one cycle after that point. A wrong pending flag is directly visible on `evt_pend` one clock after the trigger, clear or acceptance.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WAKE   = 2'd1,
    ST_ENTER  = 2'd2,
    ST_RETURN = 2'd3
  } seq_state_e;
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int unsigned NUM_EVT = 4,
  parameter int unsigned IDX_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_trig,
  input  logic [NUM_EVT-1:0] evt_clr,
  input  logic               take,
  input  logic [IDX_W-1:0]   take_idx,
  output logic [NUM_EVT-1:0] pend
);
  for (genvar g = 0; g < NUM_EVT; g++) begin : g_flag
    logic served;
    assign served = take && (take_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend[g] <= 1'b0;
      else        pend[g] <= evt_trig[g] | (pend[g] & ~evt_clr[g] & ~served);
    end

    // R1: an event always leaves its flag set
    assert_latch_R1: assert property (@(posedge clk) disable iff (!rst_n)
      evt_trig[g] |=> pend[g]);
    // R1: a clear without a new event empties the flag
    assert_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_clr[g] && !evt_trig[g]) |=> !pend[g]);
    // R2: acceptance drops the served flag
    assert_served_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (served && !evt_trig[g]) |=> !pend[g]);
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int unsigned NUM_EVT = 4,
  parameter int unsigned NUM_LVL = 2,
  parameter int unsigned IDX_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_pend,
  input  logic [NUM_EVT-1:0] evt_en,
  input  logic [NUM_LVL-1:0] lvl_req,
  input  logic [NUM_LVL-1:0] lvl_en,
  output logic               any_req,
  output logic [IDX_W-1:0]   win_idx
);
  localparam int unsigned NSRC = NUM_EVT + NUM_LVL;

  logic [NSRC-1:0] elig;
  assign elig = {lvl_req & lvl_en, evt_pend & evt_en};

  always_comb begin
    win_idx = '0;
    any_req = 1'b0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (elig[i]) begin
        win_idx = IDX_W'(i);
        any_req = 1'b1;
      end
    end
  end

  // R4: the reported winner is itself eligible
  assert_winner_eligible_R4: assert property (@(posedge clk) disable iff (!rst_n)
    any_req |-> elig[win_idx]);
  // R3: nothing requests when no source is eligible
  assert_no_phantom_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (elig == '0) |-> !any_req);
endmodule

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
  import irq_seq_pkg::*;
#(
  parameter int unsigned IDX_W      = 3,
  parameter int unsigned SP_W       = 16,
  parameter logic [SP_W-1:0] SP_TOP = 16'h005F,
  parameter int unsigned PHASE_CYC  = 4,
  parameter int unsigned PUSH_BYTES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             any_req,
  input  logic [IDX_W-1:0] win_idx,
  input  logic             insn_done,
  input  logic             multi_busy,
  input  logic             sleeping,
  input  logic             cmd_gie_set,
  input  logic             cmd_gie_clr,
  input  logic             cmd_reti,
  output logic             take,
  output logic             gie,
  output logic             vec_valid,
  output logic [IDX_W-1:0] vec_idx,
  output logic             sp_push,
  output logic             sp_pop,
  output logic [SP_W-1:0]  sp,
  output logic             stall
);
  localparam int unsigned CNT_W = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT  = CNT_W'(PHASE_CYC - 1);
  localparam logic [CNT_W-1:0] BYTE_LIM  = CNT_W'(PUSH_BYTES);
  localparam logic [SP_W-1:0]  SP_ONE    = SP_W'(1);

  seq_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             gap_q;
  logic             boundary, idle, last, accept_pt, gie_eff, ret_end;

  assign boundary  = insn_done & ~multi_busy;
  assign idle      = (state_q == ST_IDLE);
  assign last      = (cnt_q == LAST_CNT);
  assign gie_eff   = gie & ~cmd_gie_clr;
  assign accept_pt = boundary ? ~cmd_gie_set : (sleeping & ~gap_q);
  assign take      = idle & any_req & gie_eff & accept_pt & ~cmd_reti;
  assign ret_end   = (state_q == ST_RETURN) & last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      vec_idx <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          cnt_q <= '0;
          if (take) begin
            state_q <= sleeping ? ST_WAKE : ST_ENTER;
            vec_idx <= win_idx;
          end else if (cmd_reti) begin
            state_q <= ST_RETURN;
          end
        end
        ST_WAKE: begin
          cnt_q <= last ? '0 : cnt_q + 1'b1;
          if (last) state_q <= ST_ENTER;
        end
        default: begin
          cnt_q <= last ? '0 : cnt_q + 1'b1;
          if (last) state_q <= ST_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie   <= 1'b0;
      gap_q <= 1'b0;
    end else begin
      if (take)                          gie <= 1'b0;
      else if (ret_end)                  gie <= 1'b1;
      else if (idle && cmd_gie_clr)      gie <= 1'b0;
      else if (idle && cmd_gie_set)      gie <= 1'b1;

      if (ret_end || (idle && cmd_gie_set && !cmd_gie_clr)) gap_q <= 1'b1;
      else if (boundary)                                     gap_q <= 1'b0;
    end
  end

  assign sp_push   = (state_q == ST_ENTER)  && (cnt_q < BYTE_LIM);
  assign sp_pop    = (state_q == ST_RETURN) && (cnt_q < BYTE_LIM);
  assign vec_valid = (state_q == ST_ENTER) && last;
  assign stall     = !idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sp <= SP_TOP;
    else if (sp_push) sp <= sp - SP_ONE;
    else if (sp_pop)  sp <= sp + SP_ONE;
  end

  // R9: each pushed byte lowers the stack pointer by one
  assert_push_dec_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sp_push |=> (sp == $past(sp) - SP_ONE));
  // R11: each popped byte raises the stack pointer by one
  assert_pop_inc_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sp_pop |=> (sp == $past(sp) + SP_ONE));
  // R5: an accepted request leaves the global enable clear
  assert_take_clears_gie_R5: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !gie);
  // R6: a disable command in idle never starts an entry
  assert_disable_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && cmd_gie_clr) |=> (state_q != ST_ENTER && state_q != ST_WAKE));
  // R11: the end of a return leaves the global enable set
  assert_ret_sets_gie_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ret_end |=> gie);
  // R10: a wake phase always leads into entry
  assert_wake_to_entry_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAKE && last) |=> (state_q == ST_ENTER));
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
  parameter int unsigned NUM_EVT    = 4,
  parameter int unsigned NUM_LVL    = 2,
  parameter int unsigned SP_W       = 16,
  parameter logic [SP_W-1:0] SP_TOP = 16'h005F,
  parameter int unsigned PHASE_CYC  = 4,
  parameter int unsigned PUSH_BYTES = 2,
  localparam int unsigned NSRC      = NUM_EVT + NUM_LVL,
  localparam int unsigned IDX_W     = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_trig,
  input  logic [NUM_EVT-1:0] evt_clr,
  input  logic [NUM_EVT-1:0] evt_en,
  input  logic [NUM_LVL-1:0] lvl_req,
  input  logic [NUM_LVL-1:0] lvl_en,
  input  logic               insn_done,
  input  logic               multi_busy,
  input  logic               sleeping,
  input  logic               cmd_gie_set,
  input  logic               cmd_gie_clr,
  input  logic               cmd_reti,
  output logic               gie,
  output logic [NUM_EVT-1:0] evt_pend,
  output logic               vec_valid,
  output logic [IDX_W-1:0]   vec_idx,
  output logic               sp_push,
  output logic               sp_pop,
  output logic [SP_W-1:0]    sp,
  output logic               stall
);
  logic             any_req, take;
  logic [IDX_W-1:0] win_idx;

  irq_pend_bank #(.NUM_EVT(NUM_EVT), .IDX_W(IDX_W)) u_pend (
    .clk(clk), .rst_n(rst_n), .evt_trig(evt_trig), .evt_clr(evt_clr),
    .take(take), .take_idx(win_idx), .pend(evt_pend)
  );

  irq_prio_pick #(.NUM_EVT(NUM_EVT), .NUM_LVL(NUM_LVL), .IDX_W(IDX_W)) u_pick (
    .clk(clk), .rst_n(rst_n), .evt_pend(evt_pend), .evt_en(evt_en),
    .lvl_req(lvl_req), .lvl_en(lvl_en), .any_req(any_req), .win_idx(win_idx)
  );

  irq_seq_fsm #(
    .IDX_W(IDX_W), .SP_W(SP_W), .SP_TOP(SP_TOP),
    .PHASE_CYC(PHASE_CYC), .PUSH_BYTES(PUSH_BYTES)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .any_req(any_req), .win_idx(win_idx),
    .insn_done(insn_done), .multi_busy(multi_busy), .sleeping(sleeping),
    .cmd_gie_set(cmd_gie_set), .cmd_gie_clr(cmd_gie_clr), .cmd_reti(cmd_reti),
    .take(take), .gie(gie), .vec_valid(vec_valid), .vec_idx(vec_idx),
    .sp_push(sp_push), .sp_pop(sp_pop), .sp(sp), .stall(stall)
  );
endmodule

// File: tb/sim_irq_entry_seq.sv
`timescale 1ns/1ps
module sim_irq_entry_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] evt_trig = '0, evt_clr = '0, evt_en = '0;
  logic [1:0] lvl_req = '0, lvl_en = '0;
  logic       insn_done = 1'b0, multi_busy = 1'b0, sleeping = 1'b0;
  logic       cmd_gie_set = 1'b0, cmd_gie_clr = 1'b0, cmd_reti = 1'b0;
  logic       gie, vec_valid, sp_push, sp_pop, stall;
  logic [3:0] evt_pend;
  logic [2:0] vec_idx;
  logic [15:0] sp;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  irq_entry_seq u0 (
    .clk(clk), .rst_n(rst_n), .evt_trig(evt_trig), .evt_clr(evt_clr),
    .evt_en(evt_en), .lvl_req(lvl_req), .lvl_en(lvl_en),
    .insn_done(insn_done), .multi_busy(multi_busy), .sleeping(sleeping),
    .cmd_gie_set(cmd_gie_set), .cmd_gie_clr(cmd_gie_clr), .cmd_reti(cmd_reti),
    .gie(gie), .evt_pend(evt_pend), .vec_valid(vec_valid), .vec_idx(vec_idx),
    .sp_push(sp_push), .sp_pop(sp_pop), .sp(sp), .stall(stall)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_return();
    cmd_reti = 1'b1; cyc(1); cmd_reti = 1'b0;
    cyc(4);
  endtask

  task automatic t_reset();
    chk("R12 gie", gie, 0);
    chk("R12 sp", sp, 16'h005F);
    chk("R12 pend", evt_pend, 0);
    chk("R12 stall", stall, 0);
  endtask

  task automatic t_event_latch();
    evt_trig = 4'b0100; cyc(1); evt_trig = '0;
    chk("R1 latch without enables", evt_pend, 4'b0100);
    cyc(3);
    chk("R1 flag holds", evt_pend, 4'b0100);
    evt_clr = 4'b0100; cyc(1); evt_clr = '0;
    chk("R1 write-one clear", evt_pend, 0);
    evt_trig = 4'b0010; evt_clr = 4'b0010; cyc(1); evt_trig = '0; evt_clr = '0;
    chk("R1 trigger beats clear", evt_pend, 4'b0010);
    evt_clr = 4'b0010; cyc(1); evt_clr = '0;
    chk("R1 cleared again", evt_pend, 0);
  endtask

  task automatic t_priority_entry();
    evt_en = 4'hF;
    evt_trig = 4'b1010; cyc(1); evt_trig = '0;
    cmd_gie_set = 1'b1; cyc(1); cmd_gie_set = 1'b0;
    chk("R7 enable set", gie, 1);
    insn_done = 1'b1; multi_busy = 1'b1; cyc(1); insn_done = 1'b0; multi_busy = 1'b0;
    chk("R5 busy blocks", stall, 0);
    insn_done = 1'b1; cyc(1); insn_done = 1'b0;
    chk("R9 stall c1", stall, 1);
    chk("R9 push c1", sp_push, 1);
    chk("R5 gie cleared", gie, 0);
    chk("R2 winner flag cleared", evt_pend, 4'b1000);
    cyc(1);
    chk("R9 push c2", sp_push, 1);
    chk("R9 sp c2", sp, 16'h005E);
    cyc(1);
    chk("R9 no push c3", sp_push, 0);
    chk("R9 sp c3", sp, 16'h005D);
    chk("R9 no vector c3", vec_valid, 0);
    cyc(1);
    chk("R9 vector c4", vec_valid, 1);
    chk("R4 lowest index", vec_idx, 1);
    cyc(1);
    chk("R9 stall ends", stall, 0);
  endtask

  task automatic t_return_gap();
    cmd_reti = 1'b1; cyc(1); cmd_reti = 1'b0;
    chk("R11 pop c1", sp_pop, 1);
    cyc(1);
    chk("R11 pop c2", sp_pop, 1);
    chk("R11 sp c2", sp, 16'h005E);
    cyc(1);
    chk("R11 sp restored", sp, 16'h005F);
    chk("R11 no pop c3", sp_pop, 0);
    cyc(1);
    chk("R11 stall c4", stall, 1);
    cyc(1);
    chk("R11 stall ends", stall, 0);
    chk("R11 gie set", gie, 1);
    sleeping = 1'b1; cyc(3);
    chk("R8 gap while asleep", stall, 0);
    sleeping = 1'b0;
    insn_done = 1'b1; cyc(1); insn_done = 1'b0;
    chk("R8 entry after instruction", stall, 1);
    cyc(3);
    chk("R4 second source", vec_idx, 3);
    cyc(1);
    do_return();
  endtask

  task automatic t_disable();
    lvl_en = 2'b01; lvl_req = 2'b01;
    insn_done = 1'b1; cmd_gie_clr = 1'b1; cyc(1); insn_done = 1'b0; cmd_gie_clr = 1'b0;
    chk("R6 same-cycle disable", stall, 0);
    chk("R6 gie cleared", gie, 0);
  endtask

  task automatic t_gie_set_gap();
    cmd_gie_set = 1'b1; insn_done = 1'b1; cyc(1); cmd_gie_set = 1'b0; insn_done = 1'b0;
    chk("R7 blocked at enable", stall, 0);
    insn_done = 1'b1; cyc(1); insn_done = 1'b0;
    chk("R7 next boundary accepts", stall, 1);
    cyc(3);
    chk("R4 level index", vec_idx, 4);
    cyc(1);
    lvl_req = '0;
    do_return();
  endtask

  task automatic t_level();
    lvl_en = 2'b00; lvl_req = 2'b10; cyc(2); lvl_req = '0;
    lvl_en = 2'b11;
    insn_done = 1'b1; cyc(1); insn_done = 1'b0;
    chk("R3 no memory", stall, 0);
    lvl_req = 2'b10;
    insn_done = 1'b1; cyc(1); insn_done = 1'b0;
    chk("R3 present level taken", stall, 1);
    cyc(3);
    chk("R3 level index", vec_idx, 5);
    cyc(1);
    lvl_req = '0;
    do_return();
  endtask

  task automatic t_sleep();
    int stalls = 0;
    int first_push = 0;
    int vec_at = 0;
    insn_done = 1'b1; cyc(1); insn_done = 1'b0;
    sleeping = 1'b1;
    evt_trig = 4'b0001; cyc(1); evt_trig = '0;
    for (int k = 0; k < 20; k++) begin
      cyc(1);
      if (stall) begin
        stalls++;
        if (sp_push && first_push == 0) first_push = stalls;
        if (vec_valid) vec_at = stalls;
      end else if (stalls > 0) begin
        break;
      end
    end
    chk("R10 total stall", stalls, 8);
    chk("R10 first push", first_push, 5);
    chk("R10 vector cycle", vec_at, 8);
    chk("R10 index", vec_idx, 0);
    sleeping = 1'b0;
    do_return();
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    t_reset();
    t_event_latch();
    t_priority_entry();
    t_return_gap();
    t_disable();
    t_gie_set_gap();
    t_level();
    t_sleep();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 20);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule